// File: doc/BRIEF.md
# Send DMA Lifecycle Controller

This block sequences a send DMA engine through its life: powered down, waiting for the hardware to start, idle, running, waiting for a halt, and two clean-up phases. One for the hardware side and one for the software side. It moves only on events. An event is a code presented together with a one-cycle valid strobe. The block changes state only for the events that are defined for its current state. Every other event leaves it unchanged.

The block drives four control levels to the engine: enable, interrupt enable, halt and drain. These come from a table indexed by the current state. The block also emits one-cycle action strobes that ask the surrounding logic for four actions: start the hardware, begin a hardware clean-up, begin a software clean-up, or tear the engine down. When that work finishes, the surrounding logic reports back with another event.

A sticky run request records whether the engine should end up running. When start-up completes, this flag decides between idle and running. For status, the block also keeps the state it last left and the last defined event it received.

Top module: `dma_life_ctrl`

## Requirements
- R1: After reset, the block is in a defined rest condition. The state is 0 (powered down), the previous state is 0, the last-event field reads 4'hF, and the run request is 0. All four control levels and all four strobes are 0.
- R2: The state and event encodings are fixed.
  - States: off=0, start-wait=1, idle=2, sw-clean-wait=3, hw-clean-wait=4, halt-wait=5, run=6.
  - Events: down=0, start=1, started=2, run=3, sw-done=4, hw-done=5, halted=6, idle=7, fault-a=8, fault-b=9, tick=10.
  - Codes 11 to 15, tick, and any event not listed for the current state change no state, flag or strobe.
- R3: In the off state:
  - Event start moves to start-wait.
  - Event run also moves to start-wait and sets the run request.
  - Event sw-done pulses teardown and stays in off.
  - None of these pulse hw_start.
- R4: In start-wait, event started moves to run (6) when the run request is 1, and to idle (2) when it is 0.
- R5: In idle, event run moves to run and sets the run request.
- R6: In run:
  - Event idle moves to halt-wait and clears the run request.
  - Events halted and fault-a move to sw-clean-wait and pulse sw_clean.
  - Event fault-b moves to halt-wait and pulses nothing.
- R7: In halt-wait, event halted moves to hw-clean-wait and pulses hw_clean. In hw-clean-wait, event hw-done moves to sw-clean-wait and pulses sw_clean.
- R8: In sw-clean-wait, event sw-done moves to start-wait and pulses hw_start.
- R9: In start-wait, sw-clean-wait, hw-clean-wait and halt-wait, event run sets the run request and event idle clears it, without a change of state.
- R10: Event down returns to off from every state except off, and the run request is unchanged.
  - From start-wait or idle, it pulses teardown.
  - From run, halt-wait or hw-clean-wait, it pulses sw_clean.
  - From sw-clean-wait, it pulses nothing.
- R11: The control levels follow the state.
  - Enable and interrupt enable are 1 only in run.
  - Halt is 1 in halt-wait, hw-clean-wait and sw-clean-wait.
  - Drain is 1 only in halt-wait.
- R12: On every change of state, the previous-state output takes the state that was left. Every defined event code (0 to 10) is stored as the last event. Codes 11 to 15 leave the stored value unchanged.
- R13: An event sampled at a clock edge updates the state and flag at that edge. The strobe it causes is high for exactly one cycle after that edge, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_code | input | 4 | Event code (R2 encoding) |
| state_o | output | 3 | Current state |
| prev_state_o | output | 3 | State last left |
| last_evt_o | output | 4 | Last defined event code, 4'hF after reset |
| run_req_o | output | 1 | Sticky run request |
| dma_en_o | output | 1 | Engine enable |
| irq_en_o | output | 1 | Engine interrupt enable |
| halt_o | output | 1 | Engine halt request |
| drain_o | output | 1 | Engine drain request |
| hw_start_o | output | 1 | Strobe: start the hardware |
| hw_clean_o | output | 1 | Strobe: begin hardware clean-up |
| sw_clean_o | output | 1 | Strobe: begin software clean-up |
| teardown_o | output | 1 | Strobe: tear the engine down |

## Verification
The assertions assume that an event is a single-cycle pulse on evt_valid. They also assume that the surrounding logic answers each action strobe only with the event that belongs to it. Under those two assumptions, the run state is never entered with the run request clear, and each strobe coincides with its target state. The stimulus drives events on the falling edge and holds evt_valid for exactly one cycle. It issues completion events only after the strobe that asks for them, except where an out-of-place event is sent on purpose to show it is ignored.

// File: rtl/dma_life_pkg.sv
package dma_life_pkg;

  localparam int ST_W = 3;
  localparam int EV_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_OFF   = 3'd0,
    ST_BOOT  = 3'd1,
    ST_IDLE  = 3'd2,
    ST_SWCLN = 3'd3,
    ST_HWCLN = 3'd4,
    ST_HALT  = 3'd5,
    ST_RUN   = 3'd6
  } life_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_DOWN    = 4'd0,
    EV_START   = 4'd1,
    EV_STARTED = 4'd2,
    EV_RUN     = 4'd3,
    EV_SWDONE  = 4'd4,
    EV_HWDONE  = 4'd5,
    EV_HALTED  = 4'd6,
    EV_IDLE    = 4'd7,
    EV_FAULT_A = 4'd8,
    EV_FAULT_B = 4'd9,
    EV_TICK    = 4'd10
  } life_ev_e;

  localparam logic [EV_W-1:0] EV_NONE = 4'hF;

  typedef struct packed {
    logic hw_start;
    logic hw_clean;
    logic sw_clean;
    logic teardown;
  } life_act_t;

  typedef struct packed {
    logic en;
    logic irq_en;
    logic halt;
    logic drain;
  } life_ctl_t;

endpackage

// File: rtl/dma_life_rst_sync.sv
module dma_life_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dma_life_next.sv
module dma_life_next
  import dma_life_pkg::*;
(
  input  life_st_e          cur_st,
  input  logic              cur_run,
  input  logic              evt_valid,
  input  logic [EV_W-1:0]   evt_code,
  output life_st_e          nxt_st,
  output logic              nxt_run,
  output life_act_t         nxt_act
);
  always_comb begin
    nxt_st  = cur_st;
    nxt_run = cur_run;
    nxt_act = '0;
    if (evt_valid) begin
      unique case (cur_st)
        ST_OFF: begin
          if (evt_code == EV_START) nxt_st = ST_BOOT;
          if (evt_code == EV_RUN) begin
            nxt_st  = ST_BOOT;
            nxt_run = 1'b1;
          end
          if (evt_code == EV_SWDONE) nxt_act.teardown = 1'b1;
        end
        ST_BOOT: begin
          if (evt_code == EV_STARTED) nxt_st = cur_run ? ST_RUN : ST_IDLE;
          if (evt_code == EV_DOWN) begin
            nxt_st = ST_OFF;
            nxt_act.teardown = 1'b1;
          end
          if (evt_code == EV_RUN)  nxt_run = 1'b1;
          if (evt_code == EV_IDLE) nxt_run = 1'b0;
        end
        ST_IDLE: begin
          if (evt_code == EV_RUN) begin
            nxt_st  = ST_RUN;
            nxt_run = 1'b1;
          end
          if (evt_code == EV_DOWN) begin
            nxt_st = ST_OFF;
            nxt_act.teardown = 1'b1;
          end
        end
        ST_SWCLN: begin
          if (evt_code == EV_SWDONE) begin
            nxt_st = ST_BOOT;
            nxt_act.hw_start = 1'b1;
          end
          if (evt_code == EV_DOWN) nxt_st = ST_OFF;
          if (evt_code == EV_RUN)  nxt_run = 1'b1;
          if (evt_code == EV_IDLE) nxt_run = 1'b0;
        end
        ST_HWCLN: begin
          if (evt_code == EV_HWDONE) begin
            nxt_st = ST_SWCLN;
            nxt_act.sw_clean = 1'b1;
          end
          if (evt_code == EV_DOWN) begin
            nxt_st = ST_OFF;
            nxt_act.sw_clean = 1'b1;
          end
          if (evt_code == EV_RUN)  nxt_run = 1'b1;
          if (evt_code == EV_IDLE) nxt_run = 1'b0;
        end
        ST_HALT: begin
          if (evt_code == EV_HALTED) begin
            nxt_st = ST_HWCLN;
            nxt_act.hw_clean = 1'b1;
          end
          if (evt_code == EV_DOWN) begin
            nxt_st = ST_OFF;
            nxt_act.sw_clean = 1'b1;
          end
          if (evt_code == EV_RUN)  nxt_run = 1'b1;
          if (evt_code == EV_IDLE) nxt_run = 1'b0;
        end
        ST_RUN: begin
          if (evt_code == EV_IDLE) begin
            nxt_st  = ST_HALT;
            nxt_run = 1'b0;
          end
          if (evt_code == EV_HALTED || evt_code == EV_FAULT_A) begin
            nxt_st = ST_SWCLN;
            nxt_act.sw_clean = 1'b1;
          end
          if (evt_code == EV_FAULT_B) nxt_st = ST_HALT;
          if (evt_code == EV_DOWN) begin
            nxt_st = ST_OFF;
            nxt_act.sw_clean = 1'b1;
          end
        end
        default: nxt_st = ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/dma_life_ctl_tbl.sv
module dma_life_ctl_tbl
  import dma_life_pkg::*;
(
  input  life_st_e  st,
  output life_ctl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (st)
      ST_RUN:   begin ctl.en = 1'b1; ctl.irq_en = 1'b1; end
      ST_HALT:  begin ctl.halt = 1'b1; ctl.drain = 1'b1; end
      ST_HWCLN: ctl.halt = 1'b1;
      ST_SWCLN: ctl.halt = 1'b1;
      default:  ctl = '0;
    endcase
  end
endmodule

// File: rtl/dma_life_ctrl.sv
module dma_life_ctrl
  import dma_life_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_valid,
  input  logic [EV_W-1:0] evt_code,
  output logic [ST_W-1:0] state_o,
  output logic [ST_W-1:0] prev_state_o,
  output logic [EV_W-1:0] last_evt_o,
  output logic            run_req_o,
  output logic            dma_en_o,
  output logic            irq_en_o,
  output logic            halt_o,
  output logic            drain_o,
  output logic            hw_start_o,
  output logic            hw_clean_o,
  output logic            sw_clean_o,
  output logic            teardown_o
);
  logic      rst_ni;
  life_st_e  st_q, st_d, prev_q;
  logic      run_q, run_d;
  life_act_t act_q, act_d;
  life_ctl_t ctl;
  logic [EV_W-1:0] last_q;
  logic      st_ce, last_ce;

  dma_life_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  dma_life_next u_next (
    .cur_st(st_q), .cur_run(run_q), .evt_valid(evt_valid),
    .evt_code(evt_code), .nxt_st(st_d), .nxt_run(run_d), .nxt_act(act_d)
  );

  dma_life_ctl_tbl u_tbl (.st(st_q), .ctl(ctl));

  assign st_ce   = evt_valid && (st_d != st_q);
  assign last_ce = evt_valid && (evt_code <= EV_TICK);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      prev_q <= ST_OFF;
    end else if (st_ce) begin
      st_q   <= st_d;
      prev_q <= st_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 1'b0;
    else if (evt_valid) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      last_q <= EV_NONE;
    else if (last_ce) last_q <= evt_code;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign state_o      = st_q;
  assign prev_state_o = prev_q;
  assign last_evt_o   = last_q;
  assign run_req_o    = run_q;
  assign dma_en_o     = ctl.en;
  assign irq_en_o     = ctl.irq_en;
  assign halt_o       = ctl.halt;
  assign drain_o      = ctl.drain;
  assign hw_start_o   = act_q.hw_start;
  assign hw_clean_o   = act_q.hw_clean;
  assign sw_clean_o   = act_q.sw_clean;
  assign teardown_o   = act_q.teardown;

  p_strobe_onehot_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({hw_start_o, hw_clean_o, sw_clean_o, teardown_o}));

  p_run_has_req_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_o == ST_RUN) |-> run_req_o);

  p_start_in_boot_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    hw_start_o |-> (state_o == ST_BOOT));

  p_hwclean_target_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    hw_clean_o |-> (state_o == ST_HWCLN));

  p_teardown_off_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    teardown_o |-> (state_o == ST_OFF));

  p_swclean_target_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    sw_clean_o |-> (state_o == ST_SWCLN || state_o == ST_OFF));

  p_undef_code_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_valid && evt_code > EV_TICK) |=> ($stable(state_o) && $stable(run_req_o)
      && $stable(last_evt_o)));

  p_prev_tracks_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_valid && st_d != st_q) |=> (prev_state_o == $past(state_o)));

  p_en_only_run_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    dma_en_o |-> (state_o == ST_RUN && !halt_o));
endmodule

// File: tb/tb_dma_life_ctrl.sv
module tb_dma_life_ctrl;
  logic       clk;
  logic       rst_n;
  logic       evt_valid;
  logic [3:0] evt_code;
  logic [2:0] state_o, prev_state_o;
  logic [3:0] last_evt_o;
  logic run_req_o, dma_en_o, irq_en_o, halt_o, drain_o;
  logic hw_start_o, hw_clean_o, sw_clean_o, teardown_o;

  int checks;
  int errors;

  dma_life_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .state_o(state_o), .prev_state_o(prev_state_o), .last_evt_o(last_evt_o),
    .run_req_o(run_req_o), .dma_en_o(dma_en_o), .irq_en_o(irq_en_o),
    .halt_o(halt_o), .drain_o(drain_o), .hw_start_o(hw_start_o),
    .hw_clean_o(hw_clean_o), .sw_clean_o(sw_clean_o), .teardown_o(teardown_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobes packed as {hw_start, hw_clean, sw_clean, teardown}
  task automatic look(input string req, input int st, input int run, input int stb);
    chk({req, " state"}, state_o, st);
    chk({req, " run_req"}, run_req_o, run);
    chk({req, " strobes"}, {hw_start_o, hw_clean_o, sw_clean_o, teardown_o}, stb);
  endtask

  task automatic send(input logic [3:0] code);
    evt_valid = 1'b1;
    evt_code  = code;
    @(negedge clk);
    evt_valid = 1'b0;
    evt_code  = 4'd0;
  endtask

  task automatic idle_cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    look("R1", 0, 0, 0);
    chk("R1 prev", prev_state_o, 0);
    chk("R1 last", last_evt_o, 15);
    chk("R1 ctl", {dma_en_o, irq_en_o, halt_o, drain_o}, 0);
  endtask

  task automatic t_boot_idle_run();
    send(4'd1);  look("R3 start", 1, 0, 0);
    chk("R11 boot ctl", {dma_en_o, irq_en_o, halt_o, drain_o}, 0);
    send(4'd2);  look("R4 to idle", 2, 0, 0);
    send(4'd3);  look("R5 run", 6, 1, 0);
    chk("R11 run ctl", {dma_en_o, irq_en_o, halt_o, drain_o}, 4'b1100);
    chk("R12 prev", prev_state_o, 2);
    chk("R12 last", last_evt_o, 3);
  endtask

  task automatic t_halt_chain();
    send(4'd7);  look("R6 idle", 5, 0, 0);
    chk("R11 halt ctl", {dma_en_o, irq_en_o, halt_o, drain_o}, 4'b0011);
    send(4'd3);  look("R9 halt set", 5, 1, 0);
    send(4'd7);  look("R9 halt clr", 5, 0, 0);
    send(4'd6);  look("R7 halted", 4, 0, 4'b0100);
    idle_cyc();  look("R13 one cycle", 4, 0, 0);
    chk("R11 hwcln ctl", {dma_en_o, irq_en_o, halt_o, drain_o}, 4'b0010);
    send(4'd5);  look("R7 hwdone", 3, 0, 4'b0010);
    chk("R11 swcln ctl", {dma_en_o, irq_en_o, halt_o, drain_o}, 4'b0010);
    send(4'd3);  look("R9 swcln set", 3, 1, 0);
    send(4'd7);  look("R9 swcln clr", 3, 0, 0);
    send(4'd4);  look("R8 swdone", 1, 0, 4'b1000);
    send(4'd2);  look("R4 idle again", 2, 0, 0);
    send(4'd3);  look("R5 run again", 6, 1, 0);
  endtask

  task automatic t_faults();
    send(4'd8);  look("R6 fault_a", 3, 1, 4'b0010);
    send(4'd4);  look("R8 swdone", 1, 1, 4'b1000);
    send(4'd2);  look("R4 to run", 6, 1, 0);
    send(4'd9);  look("R6 fault_b", 5, 1, 0);
    send(4'd10); look("R2 tick", 5, 1, 0);
    chk("R12 last tick", last_evt_o, 10);
    send(4'd13); look("R2 undefined", 5, 1, 0);
    chk("R12 last kept", last_evt_o, 10);
    send(4'd1);  look("R2 unlisted", 5, 1, 0);
    send(4'd0);  look("R10 down halt", 0, 1, 4'b0010);
    chk("R12 prev halt", prev_state_o, 5);
  endtask

  task automatic t_down_paths();
    send(4'd4);  look("R3 teardown", 0, 1, 4'b0001);
    send(4'd1);  look("R3 start", 1, 1, 0);
    send(4'd2);  look("R4 flag run", 6, 1, 0);
    send(4'd0);  look("R10 down run", 0, 1, 4'b0010);
    send(4'd1);  look("R3 start2", 1, 1, 0);
    send(4'd0);  look("R10 down boot", 0, 1, 4'b0001);
    send(4'd3);  look("R3 run evt", 1, 1, 0);
    send(4'd7);  look("R9 boot clr", 1, 0, 0);
    send(4'd2);  look("R4 idle", 2, 0, 0);
    send(4'd0);  look("R10 down idle", 0, 0, 4'b0001);
    send(4'd1);  send(4'd2); look("R4 idle2", 2, 0, 0);
    send(4'd3);  send(4'd6); look("R6 halted", 3, 1, 4'b0010);
    send(4'd0);  look("R10 down swcln", 0, 1, 0);
    send(4'd1);  send(4'd2); send(4'd7); send(4'd6);
    look("R7 hwcln", 4, 0, 4'b0100);
    send(4'd0);  look("R10 down hwcln", 0, 0, 4'b0010);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    evt_valid = 1'b0;
    evt_code  = 4'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_boot_idle_run();
    t_halt_chain();
    t_faults();
    t_down_paths();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule